// File: doc/BRIEF.md
# Preloaded Loop Store Fetch Controller

This block sits beside the level-one instruction cache and answers instruction fetches for a few hot code regions out of a small local store. Both the store and a region table are written before the program runs, with regions picked offline by profiling. Nothing is filled while the program runs, so there are no fill cycles. A region may hold conditional branches and subroutine calls. Fetches that branch from one stored region into another stay in the store.

The first fetch in a region is served only if the fetch PC equals that region's start address. The controller is then active. While it is active, any fetch PC inside the address range of any valid region is served. The store index is the region's base index plus the word offset of the PC from the region start. Each stored word has an exit flag.

The controller goes back to cold (inactive) when any of these happens:
- the served word has its exit flag set;
- a taken branch on the served word points outside every valid region;
- a fetch misses.

Whenever a fetch is served, the cache is told to stay idle through the disable output.

Top module: `lpstore_ctrl`

## Requirements
- R1: After reset the controller is cold, `l1_disable` is 0 and `lc_instr` is zero.
- R2: While cold, a fetch is served in the same cycle only when `fetch_pc` equals the start address of a valid region. A PC inside a region but not at its start misses.
- R3: A served fetch returns the store word at index (base + (fetch_pc − start) / 4) mod DEPTH, where 4 is 2^WORD_LG bytes. While active, a PC anywhere in [start, end] of any valid region is served, including a region other than the one entered.
- R4: When a served word has its exit flag set, the controller is cold on the next fetch.
- R5: When `br_taken` is high on a served fetch and `br_target` lies outside every valid region, the controller is cold on the next fetch. When the target lies inside a valid region, the controller stays active.
- R6: A fetch that is not served drives `l1_disable` to 0 and `lc_instr` to zero, and leaves the controller cold.
- R7: Store writes and region-table writes are accepted only while the controller is cold. While it is active they are dropped and leave no trace.
- R8: When several regions match, the lowest-numbered matching region supplies the start address and the base index.
- R9: A region entry whose valid field is 0 never matches, neither as an entry point nor as a range.
- R10: A cycle with `fetch_req` low serves nothing and leaves the active or cold state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_we | input | 1 | Store word write strobe |
| st_idx | input | IDX_W | Store index to write |
| st_word | input | DATA_W | Instruction word to write |
| st_exit | input | 1 | Exit flag written with the word |
| rg_we | input | 1 | Region table write strobe |
| rg_sel | input | RID_W | Region entry to write |
| rg_valid | input | 1 | Valid field of the entry |
| rg_start | input | ADDR_W | Byte address of the first word of the region |
| rg_end | input | ADDR_W | Byte address of the last word of the region (inclusive) |
| rg_base | input | IDX_W | Store index holding the first word |
| fetch_req | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | ADDR_W | Fetch byte address |
| br_taken | input | 1 | The served word resolves as a taken branch |
| br_target | input | ADDR_W | Target of that branch |
| lc_instr | output | DATA_W | Word served from the store, zero on a miss |
| l1_disable | output | 1 | High when the store serves the fetch |

## Verification
Two cases are hard to reach from the ports: a load write dropped while the controller is active (R7), and the resolution of overlapping regions (R8). To make a write be dropped, the bench first enters a region with a cold fetch at its start. In the following served cycle it drives a store write and a region rebase together with that fetch. It then leaves the region and re-enters it cold, which shows that both the word and the base index are unchanged. Overlap is exercised by placing one region inside another. A cold fetch at the inner start picks the inner region's base. An active fetch in the shared range picks the outer, lower-numbered entry.

// File: rtl/lps_pkg.sv
package lps_pkg;

   // Which comparison the region table applies to the fetch PC
   typedef enum logic {
      LK_ENTRY  = 1'b0,   // cold: PC must equal a region start
      LK_RESUME = 1'b1    // active: PC may lie anywhere in a region range
   } lk_mode_e;

endpackage

// File: rtl/lps_region_tab.sv
module lps_region_tab
   import lps_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 6,
   parameter int REGIONS = 4,
   parameter int RID_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RID_W-1:0]  wr_sel,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_start,
   input  logic [ADDR_W-1:0] wr_end,
   input  logic [IDX_W-1:0]  wr_base,
   input  lk_mode_e          mode,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] target,
   output logic              hit,
   output logic [ADDR_W-1:0] hit_start,
   output logic [IDX_W-1:0]  hit_base,
   output logic              entry_any,
   output logic              target_any
);

   logic              vld_q   [REGIONS];
   logic [ADDR_W-1:0] start_q [REGIONS];
   logic [ADDR_W-1:0] end_q   [REGIONS];
   logic [IDX_W-1:0]  base_q  [REGIONS];

   logic [REGIONS-1:0] at_start;
   logic [REGIONS-1:0] in_range;
   logic [REGIONS-1:0] tgt_range;
   logic [REGIONS-1:0] pick;
   logic [RID_W-1:0]   sel;

   for (genvar r = 0; r < REGIONS; r++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[r]   <= 1'b0;
            start_q[r] <= '0;
            end_q[r]   <= '0;
            base_q[r]  <= '0;
         end else if (wr_en && (wr_sel == RID_W'(r))) begin
            vld_q[r]   <= wr_valid;
            start_q[r] <= wr_start;
            end_q[r]   <= wr_end;
            base_q[r]  <= wr_base;
         end
      end

      assign at_start[r]  = vld_q[r] && (pc == start_q[r]);
      assign in_range[r]  = vld_q[r] && (pc >= start_q[r]) && (pc <= end_q[r]);
      assign tgt_range[r] = vld_q[r] && (target >= start_q[r]) && (target <= end_q[r]);
   end

   assign pick = (mode == LK_RESUME) ? in_range : at_start;

   // lowest-numbered match wins
   always_comb begin
      sel = '0;
      for (int r = REGIONS - 1; r >= 0; r--) begin
         if (pick[r]) sel = RID_W'(r);
      end
   end

   assign hit        = |pick;
   assign hit_start  = start_q[sel];
   assign hit_base   = base_q[sel];
   assign entry_any  = |at_start;
   assign target_any = |tgt_range;

endmodule

// File: rtl/lps_index.sv
module lps_index #(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 6,
   parameter int WORD_LG = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] start,
   input  logic [IDX_W-1:0]  base,
   output logic [IDX_W-1:0]  idx
);

   logic [ADDR_W-1:0] diff;
   logic [ADDR_W-1:0] words;
   logic              upper_unused;

   assign diff  = pc - start;
   assign words = diff >> WORD_LG;
   // wraps modulo the store depth
   assign idx   = base + words[IDX_W-1:0];

   assign upper_unused = ^words[ADDR_W-1:IDX_W];

endmodule

// File: rtl/lps_store.sv
module lps_store #(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 64,
   parameter int IDX_W          = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              wr_exit,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word,
   output logic              rd_exit
);

   localparam int ROW_W = DATA_W + 1;

   logic [ROW_W-1:0] mem_q [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_en) begin
            mem_q[wr_idx] <= {wr_exit, wr_word};
         end
      end
   end else begin : g_plain
      logic rst_unused;
      assign rst_unused = rst_n;
      always_ff @(posedge clk) begin
         if (wr_en) mem_q[wr_idx] <= {wr_exit, wr_word};
      end
   end

   assign rd_word = mem_q[rd_idx][DATA_W-1:0];
   assign rd_exit = mem_q[rd_idx][DATA_W];

endmodule

// File: rtl/lpstore_ctrl.sv
module lpstore_ctrl
   import lps_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 64,
   parameter int REGIONS        = 4,
   parameter int WORD_LG        = 2,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(DEPTH),
   localparam int RID_W         = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  logic [IDX_W-1:0]  st_idx,
   input  logic [DATA_W-1:0] st_word,
   input  logic              st_exit,
   input  logic              rg_we,
   input  logic [RID_W-1:0]  rg_sel,
   input  logic              rg_valid,
   input  logic [ADDR_W-1:0] rg_start,
   input  logic [ADDR_W-1:0] rg_end,
   input  logic [IDX_W-1:0]  rg_base,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   output logic [DATA_W-1:0] lc_instr,
   output logic              l1_disable
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      initial $error("lpstore_ctrl: DEPTH must be a power of two of at least 2");
   end
   if (REGIONS < 1) begin : g_bad_regions
      initial $error("lpstore_ctrl: REGIONS must be at least 1");
   end
   if (ADDR_W <= IDX_W + WORD_LG) begin : g_bad_addr
      initial $error("lpstore_ctrl: ADDR_W too narrow for the store");
   end

   logic              active_q;
   logic              active_d;
   lk_mode_e          mode;
   logic              tab_hit;
   logic [ADDR_W-1:0] hit_start;
   logic [IDX_W-1:0]  hit_base;
   logic              entry_any;
   logic              tgt_any;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_word;
   logic              rd_exit;
   logic              serve;
   logic              st_we_ok;
   logic              rg_we_ok;

   assign mode     = active_q ? LK_RESUME : LK_ENTRY;
   assign st_we_ok = st_we && !active_q;
   assign rg_we_ok = rg_we && !active_q;

   lps_region_tab #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .REGIONS(REGIONS),
      .RID_W  (RID_W)
   ) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (rg_we_ok),
      .wr_sel    (rg_sel),
      .wr_valid  (rg_valid),
      .wr_start  (rg_start),
      .wr_end    (rg_end),
      .wr_base   (rg_base),
      .mode      (mode),
      .pc        (fetch_pc),
      .target    (br_target),
      .hit       (tab_hit),
      .hit_start (hit_start),
      .hit_base  (hit_base),
      .entry_any (entry_any),
      .target_any(tgt_any)
   );

   lps_index #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .WORD_LG(WORD_LG)
   ) u_idx (
      .pc   (fetch_pc),
      .start(hit_start),
      .base (hit_base),
      .idx  (rd_idx)
   );

   lps_store #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .IDX_W         (IDX_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (st_we_ok),
      .wr_idx (st_idx),
      .wr_word(st_word),
      .wr_exit(st_exit),
      .rd_idx (rd_idx),
      .rd_word(rd_word),
      .rd_exit(rd_exit)
   );

   assign serve      = fetch_req && tab_hit;
   assign l1_disable = serve;
   assign lc_instr   = serve ? rd_word : '0;

   always_comb begin
      active_d = active_q;
      if (fetch_req) begin
         active_d = serve && !rd_exit && !(br_taken && !tgt_any);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_d;
   end

endmodule

// File: rtl/lpstore_ctrl_chk.sv
module lpstore_ctrl_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              br_taken,
   input logic              l1_disable,
   input logic [DATA_W-1:0] lc_instr,
   input logic              active,
   input logic              exit_bit,
   input logic              tgt_any,
   input logic              entry_any
);

   AST_IDLE_NO_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |-> !l1_disable) else $error("idle cycle served");          // R10

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |=> $stable(active)) else $error("state moved on stall");   // R10

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_disable |-> (lc_instr == '0)) else $error("miss drove data");      // R6

   AST_EXIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_disable && exit_bit) |=> !active) else $error("exit ignored");     // R4

   AST_ESCAPE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_disable && br_taken && !tgt_any) |=> !active) else $error("escape ignored"); // R5

   AST_COLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && l1_disable) |-> entry_any) else $error("cold mid-region serve");     // R2

endmodule

bind lpstore_ctrl lpstore_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_req (fetch_req),
   .br_taken  (br_taken),
   .l1_disable(l1_disable),
   .lc_instr  (lc_instr),
   .active    (active_q),
   .exit_bit  (rd_exit),
   .tgt_any   (tgt_any),
   .entry_any (entry_any)
);

// File: tb/lpstore_ctrl_test.sv
module lpstore_ctrl_test;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 64;
   localparam int IW = 6;
   localparam int RW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_we = 1'b0;
   logic [IW-1:0] st_idx = '0;
   logic [DW-1:0] st_word = '0;
   logic          st_exit = 1'b0;
   logic          rg_we = 1'b0;
   logic [RW-1:0] rg_sel = '0;
   logic          rg_valid = 1'b0;
   logic [AW-1:0] rg_start = '0;
   logic [AW-1:0] rg_end = '0;
   logic [IW-1:0] rg_base = '0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          br_taken = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic [DW-1:0] lc_instr;
   logic          l1_disable;

   always #4 clk = ~clk;   // 125 MHz

   lpstore_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .st_we(st_we), .st_idx(st_idx), .st_word(st_word), .st_exit(st_exit),
      .rg_we(rg_we), .rg_sel(rg_sel), .rg_valid(rg_valid),
      .rg_start(rg_start), .rg_end(rg_end), .rg_base(rg_base),
      .fetch_req(fetch_req), .fetch_pc(fetch_pc),
      .br_taken(br_taken), .br_target(br_target),
      .lc_instr(lc_instr), .l1_disable(l1_disable)
   );

   typedef struct {
      logic          hit;
      logic [DW-1:0] word;
      string         tag;
   } exp_t;

   exp_t          sb_q[$];
   logic [DW-1:0] m_word [DEPTH];
   logic          m_exit [DEPTH];
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;

   // pending load strobes applied together with the next fetch
   bit            p_st = 1'b0;
   logic [IW-1:0] p_st_idx = '0;
   logic [DW-1:0] p_st_word = '0;
   bit            p_rg = 1'b0;
   logic [RW-1:0] p_rg_sel = '0;
   logic [IW-1:0] p_rg_base = '0;

   task automatic clear_inputs();
      st_we = 1'b0; rg_we = 1'b0; fetch_req = 1'b0; br_taken = 1'b0;
   endtask

   task automatic load_word(input int idx, input logic [DW-1:0] w, input logic ex);
      @(negedge clk);
      clear_inputs();
      st_we = 1'b1; st_idx = IW'(idx); st_word = w; st_exit = ex;
      m_word[idx] = w; m_exit[idx] = ex;
   endtask

   task automatic load_region(input int r, input logic v, input logic [AW-1:0] s,
                              input logic [AW-1:0] e, input int b);
      @(negedge clk);
      clear_inputs();
      rg_we = 1'b1; rg_sel = RW'(r); rg_valid = v; rg_start = s; rg_end = e; rg_base = IW'(b);
   endtask

   // driver: one fetch cycle, expected result pushed to the scoreboard
   task automatic fetch(input logic req, input logic [AW-1:0] pc, input logic br,
                        input logic [AW-1:0] tgt, input logic hit, input int idx,
                        input string tag);
      exp_t e;
      @(negedge clk);
      clear_inputs();
      fetch_req = req; fetch_pc = pc; br_taken = br; br_target = tgt;
      if (p_st) begin
         st_we = 1'b1; st_idx = p_st_idx; st_word = p_st_word; st_exit = 1'b0;
         p_st = 1'b0;
      end
      if (p_rg) begin
         rg_we = 1'b1; rg_sel = p_rg_sel; rg_valid = 1'b1;
         rg_start = 32'h200; rg_end = 32'h20C; rg_base = p_rg_base;
         p_rg = 1'b0;
      end
      e.hit  = hit;
      e.word = hit ? m_word[idx] : '0;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (l1_disable !== e.hit || lc_instr !== e.word) begin
               n_bad++;
               $display("FAIL %s: l1_disable=%0b lc_instr=%h expected l1_disable=%0b lc_instr=%h",
                        e.tag, l1_disable, lc_instr, e.hit, e.word);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_word[i] = 32'hC0DE_0000 + DW'(i);
         m_exit[i] = (i == 7);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      fetch(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 0, "R1 reset state");

      for (int i = 0; i < DEPTH; i++) load_word(i, m_word[i], m_exit[i]);
      load_region(0, 1'b1, 32'h100, 32'h11C, 0);
      load_region(1, 1'b1, 32'h200, 32'h20C, 8);
      load_region(2, 1'b1, 32'h104, 32'h10C, 20);
      load_region(3, 1'b0, 32'h300, 32'h30C, 30);

      fetch(1'b1, 32'h108, 1'b0, 0, 1'b0, 0, "R2 cold mid-region miss");
      fetch(1'b1, 32'h100, 1'b0, 0, 1'b1, 0, "R2 cold entry at start");
      fetch(1'b1, 32'h104, 1'b0, 0, 1'b1, 1, "R8 active overlap lowest");
      fetch(1'b1, 32'h108, 1'b1, 32'h200, 1'b1, 2, "R5 branch inside region");
      fetch(1'b1, 32'h200, 1'b0, 0, 1'b1, 8, "R3 subroutine region");
      fetch(1'b1, 32'h204, 1'b1, 32'h400, 1'b1, 9, "R5 branch escape served");
      fetch(1'b1, 32'h208, 1'b0, 0, 1'b0, 0, "R5 cold after escape");
      fetch(1'b1, 32'h100, 1'b0, 0, 1'b1, 0, "R2 re-entry");
      fetch(1'b0, 32'h104, 1'b0, 0, 1'b0, 0, "R10 stall serves nothing");
      fetch(1'b1, 32'h104, 1'b0, 0, 1'b1, 1, "R10 active held over stall");
      fetch(1'b1, 32'h11C, 1'b0, 0, 1'b1, 7, "R3 last word with exit flag");
      fetch(1'b1, 32'h108, 1'b0, 0, 1'b0, 0, "R4 cold after exit flag");
      fetch(1'b1, 32'h100, 1'b0, 0, 1'b1, 0, "R2 entry again");
      fetch(1'b1, 32'h500, 1'b0, 0, 1'b0, 0, "R6 out-of-region miss");
      fetch(1'b1, 32'h104, 1'b0, 0, 1'b1, 20, "R8 cold entry inner region");
      fetch(1'b1, 32'h300, 1'b0, 0, 1'b0, 0, "R9 invalid range while active");
      fetch(1'b1, 32'h300, 1'b0, 0, 1'b0, 0, "R9 invalid start while cold");

      fetch(1'b1, 32'h200, 1'b0, 0, 1'b1, 8, "R7 entry before blocked load");
      p_st = 1'b1; p_st_idx = 6'd8; p_st_word = 32'hDEAD_BEEF;
      p_rg = 1'b1; p_rg_sel = 2'd1; p_rg_base = 6'd40;
      fetch(1'b1, 32'h204, 1'b0, 0, 1'b1, 9, "R7 fetch with blocked load");
      fetch(1'b1, 32'h200, 1'b0, 0, 1'b1, 8, "R7 word kept while active");
      fetch(1'b1, 32'h600, 1'b0, 0, 1'b0, 0, "R6 leave region");
      fetch(1'b1, 32'h200, 1'b0, 0, 1'b1, 8, "R7 base and word kept");
      fetch(1'b1, 32'h900, 1'b0, 0, 1'b0, 0, "R6 leave region again");

      load_region(1, 1'b1, 32'h200, 32'h20C, 62);
      load_word(63, 32'h1234_5678, 1'b0);
      fetch(1'b1, 32'h200, 1'b0, 0, 1'b1, 62, "R7 rebase accepted when cold");
      fetch(1'b1, 32'h204, 1'b0, 0, 1'b1, 63, "R7 word write accepted when cold");
      fetch(1'b1, 32'h208, 1'b0, 0, 1'b1, 0, "R3 index wraps modulo depth");

      @(negedge clk);
      clear_inputs();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule